// File: doc/BRIEF.md
# Sine Test Bit-Stream Generator

This block turns a stored table of signed sine samples into a one-bit delta-sigma stream that can drive an external test DAC. Software fills the table through a simple write port. It then sets the last valid table index, an interpolation factor, a bit-rate selector and a 24-bit gain, and raises `run_en`. The block steps through the table with linear interpolation between neighbouring entries. It scales each interpolated value by the gain and feeds it to a second-order modulator with a one-bit quantizer. It drives a bit clock and a data line, and the data line changes only when the bit clock falls.

With `P` points in use (`cfg_last + 1`) and interpolation setting `I`, one sine period takes `P * (I + 1)` bits. The tone frequency is therefore the bit rate divided by that product. For example, 1024 points with a setting of 7 at 256 kbit/s give 31.25 Hz. The interpolator forms the interpolated value as `(I + 1)` times the straight-line value, which avoids a divider. Software compensates through the gain. When phase resync is enabled, a rising edge on `sync_in` restarts the table phase and the bit clock, so several generators can be aligned.

The table write port accepts a write on every cycle and has no back-pressure. The stream outputs are free-running pins with no handshake. The consumer samples data on the rising bit-clock edge.

Top module: `tbs_gen`

## Requirements
- R1: When `tbl_we` is high at a rising `clk` edge, the 24-bit two's-complement word `tbl_wdata` is stored at entry `tbl_waddr`. The next bits produced from that entry use the new value.
- R2: While running, the bit clock has a period of `2 << cfg_rate` cycles of `clk`. A counter restarts at 0, and `bit_clk_o` is high during the cycles in which the counter's next value is below half the period.
- R3: `bit_data_o` changes only in a cycle where `bit_clk_o` falls from 1 to 0, and it produces one new bit per bit-clock period.
- R4: With N = `cfg_interp + 1`, the value fed to scaling at sub-step s (0..N-1) between entries a and b is `a*(N-s) + b*s`. Each entry covers N bits.
- R5: After entry `cfg_last`, the phase wraps to entry 0, and entry 0 also serves as the right-hand neighbour of `cfg_last`.
- R6: The modulator input is floor(value × `cfg_gain` / 2^24), where the gain is unsigned.
- R7: On each bit, the feedback y is +2^23 if the second integrator is non-negative and −2^23 otherwise. The first integrator then adds input − y, and the second adds the new first-integrator value − y. The bit is 1 when the new second-integrator value is ≥ 0.
- R8: While `run_en` is low, `bit_clk_o` and `bit_data_o` are 0 one cycle later, and the phase, the bit-clock counter and both integrators are cleared.
- R9: With `cfg_sync_en` high, a rising edge on `sync_in` while running restarts the table phase at entry 0, sub-step 0, and forces the bit clock low with its counter at 0. The data bit and the integrators are held.
- R10: With `cfg_sync_en` low, edges on `sync_in` do not affect the stream.
- R11: For a constant table value producing a modulator input u, the fraction of ones over many bits is (1 + u/2^23)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 10 | Table write index |
| tbl_wdata | input | 24 | Signed sample to store |
| run_en | input | 1 | Generator enable; low clears the stream state |
| cfg_interp | input | 8 | Interpolation setting I (I+1 bits per entry) |
| cfg_rate | input | 3 | Bit-rate selector, period 2 << value clocks |
| cfg_gain | input | 24 | Unsigned amplitude gain, unity = 2^24 |
| cfg_last | input | 10 | Index of the last table entry in use |
| cfg_sync_en | input | 1 | Enables phase restart on `sync_in` rising edge |
| sync_in | input | 1 | Synchronous phase-alignment input |
| bit_clk_o | output | 1 | Bit clock |
| bit_data_o | output | 1 | Delta-sigma data, changes on bit-clock fall |

## Verification
The assertions rely on three properties of the inputs. First, the configuration fields stay constant while `run_en` is high. Second, `sync_in` is synchronous to `clk`. Third, every scaled modulator input stays below three quarters of 2^23, which keeps the integrators inside their bound. The stimulus changes configuration only after `run_en` has been low for several cycles. It drives `sync_in` and the table port on the falling clock edge. Its test tables have a peak magnitude of half of full scale after scaling, with gains chosen for each interpolation setting.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int DATA_W   = 24;
  localparam int ADDR_W   = 10;
  localparam int INTERP_W = 8;
  localparam int RATE_W   = 3;
  localparam int GAIN_W   = 24;
  localparam int ACC_W    = 40;
endpackage

// File: rtl/tbs_clkdiv.sv
module tbs_clkdiv #(
  parameter int RATE_W = tbs_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              bit_clk,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) + 1;

  logic [CNT_W-1:0] period, half, cnt, cnt_n;

  assign period = CNT_W'(2) << rate;
  assign half   = period >> 1;
  assign cnt_n  = (cnt == period - 1'b1) ? '0 : cnt + 1'b1;
  // a new bit is due only on a genuine high-to-low transition
  assign tick   = run && !restart && bit_clk && (cnt_n == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
    end else if (!run || restart) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      bit_clk <= (cnt_n < half);
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));
endmodule

// File: rtl/tbs_table.sv
module tbs_table #(
  parameter int DATA_W = tbs_pkg::DATA_W,
  parameter int ADDR_W = tbs_pkg::ADDR_W
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        ra_cur,
  input  logic [ADDR_W-1:0]        ra_nxt,
  output logic signed [DATA_W-1:0] rd_cur,
  output logic signed [DATA_W-1:0] rd_nxt,
  output logic signed [DATA_W-1:0] rd_zero
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_cur  = mem[ra_cur];
  assign rd_nxt  = mem[ra_nxt];
  assign rd_zero = mem[0];
endmodule

// File: rtl/tbs_phase.sv
module tbs_phase #(
  parameter int DATA_W   = tbs_pkg::DATA_W,
  parameter int ADDR_W   = tbs_pkg::ADDR_W,
  parameter int INTERP_W = tbs_pkg::INTERP_W,
  parameter int XW       = DATA_W + INTERP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     restart,
  input  logic                     tick,
  input  logic [INTERP_W-1:0]      interp,
  input  logic [ADDR_W-1:0]        last,
  input  logic signed [DATA_W-1:0] rd_cur,
  input  logic signed [DATA_W-1:0] rd_nxt,
  input  logic signed [DATA_W-1:0] rd_zero,
  output logic [ADDR_W-1:0]        idx,
  output logic [ADDR_W-1:0]        nxt_idx,
  output logic signed [XW-1:0]     x
);
  logic [INTERP_W:0]        npts;
  logic signed [XW-1:0]     nscale, cur_e, nxt_e, zero_e;
  logic [INTERP_W-1:0]      sub;

  assign npts    = {1'b0, interp} + 1'b1;
  assign nscale  = $signed(XW'(npts));
  assign cur_e   = XW'(rd_cur);
  assign nxt_e   = XW'(rd_nxt);
  assign zero_e  = XW'(rd_zero);
  assign nxt_idx = (idx == last) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      sub <= '0;
      x   <= '0;
    end else if (!run || restart) begin
      idx <= '0;
      sub <= '0;
      x   <= nscale * zero_e;
    end else if (tick) begin
      if (sub == interp) begin
        sub <= '0;
        idx <= nxt_idx;
        x   <= nscale * nxt_e;
      end else begin
        sub <= sub + 1'b1;
        x   <= x + nxt_e - cur_e;
      end
    end
  end

  p_sub_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (sub <= interp));
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx <= last));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx == '0 && sub == '0));
endmodule

// File: rtl/tbs_dsm.sv
module tbs_dsm #(
  parameter int DATA_W = tbs_pkg::DATA_W,
  parameter int GAIN_W = tbs_pkg::GAIN_W,
  parameter int ACC_W  = tbs_pkg::ACC_W,
  parameter int XW     = DATA_W + tbs_pkg::INTERP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic signed [XW-1:0] x,
  input  logic [GAIN_W-1:0]    gain,
  output logic                 bit_o
);
  localparam int PW = XW + GAIN_W + 1;
  localparam logic signed [ACC_W-1:0] FS  = $signed(ACC_W'(1) << (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] LIM = $signed(ACC_W'(1) << (DATA_W + 7));

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] u, y, i1, i2, i1_n, i2_n;

  assign prod = PW'(x) * $signed(PW'({1'b0, gain}));
  assign u    = ACC_W'(prod >>> GAIN_W);
  assign y    = (i2 >= 0) ? FS : -FS;
  assign i1_n = i1 + u - y;
  assign i2_n = i2 + i1_n - y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i1    <= '0;
      i2    <= '0;
      bit_o <= 1'b0;
    end else if (!run) begin
      i1    <= '0;
      i2    <= '0;
      bit_o <= 1'b0;
    end else if (tick) begin
      i1    <= i1_n;
      i2    <= i2_n;
      bit_o <= (i2_n >= 0);
    end
  end

  p_loop_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i2 < LIM) && (i2 > -LIM));
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bit_o));
endmodule

// File: rtl/tbs_gen.sv
module tbs_gen #(
  parameter int DATA_W   = tbs_pkg::DATA_W,
  parameter int ADDR_W   = tbs_pkg::ADDR_W,
  parameter int INTERP_W = tbs_pkg::INTERP_W,
  parameter int RATE_W   = tbs_pkg::RATE_W,
  parameter int GAIN_W   = tbs_pkg::GAIN_W,
  parameter int ACC_W    = tbs_pkg::ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_we,
  input  logic [ADDR_W-1:0]   tbl_waddr,
  input  logic [DATA_W-1:0]   tbl_wdata,
  input  logic                run_en,
  input  logic [INTERP_W-1:0] cfg_interp,
  input  logic [RATE_W-1:0]   cfg_rate,
  input  logic [GAIN_W-1:0]   cfg_gain,
  input  logic [ADDR_W-1:0]   cfg_last,
  input  logic                cfg_sync_en,
  input  logic                sync_in,
  output logic                bit_clk_o,
  output logic                bit_data_o
);
  localparam int XW = DATA_W + INTERP_W + 1;

  logic                     sync_q, restart, tick;
  logic [ADDR_W-1:0]        idx, nxt_idx;
  logic signed [DATA_W-1:0] rd_cur, rd_nxt, rd_zero;
  logic signed [XW-1:0]     x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign restart = run_en && cfg_sync_en && sync_in && !sync_q;

  tbs_clkdiv #(.RATE_W(RATE_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(run_en), .restart(restart),
    .rate(cfg_rate), .bit_clk(bit_clk_o), .tick(tick)
  );

  tbs_table #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata($signed(tbl_wdata)),
    .ra_cur(idx), .ra_nxt(nxt_idx),
    .rd_cur(rd_cur), .rd_nxt(rd_nxt), .rd_zero(rd_zero)
  );

  tbs_phase #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INTERP_W(INTERP_W), .XW(XW)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_en), .restart(restart), .tick(tick),
    .interp(cfg_interp), .last(cfg_last),
    .rd_cur(rd_cur), .rd_nxt(rd_nxt), .rd_zero(rd_zero),
    .idx(idx), .nxt_idx(nxt_idx), .x(x)
  );

  tbs_dsm #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W), .XW(XW)) u_dsm (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
    .x(x), .gain(cfg_gain), .bit_o(bit_data_o)
  );

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!bit_clk_o && !bit_data_o));
  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && !$stable(bit_data_o)) |-> $fell(bit_clk_o));
endmodule

// File: tb/tb_tbs_gen.sv
`timescale 1ns/1ps
module tb_tbs_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_waddr = '0;
  logic [23:0] tbl_wdata = '0;
  logic        run_en = 1'b0;
  logic [7:0]  cfg_interp = '0;
  logic [2:0]  cfg_rate = '0;
  logic [23:0] cfg_gain = '0;
  logic [9:0]  cfg_last = '0;
  logic        cfg_sync_en = 1'b0;
  logic        sync_in = 1'b0;
  logic        bit_clk_o, bit_data_o;

  always #5 clk = ~clk;

  tbs_gen dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R8";

  // behavioural reference state
  longint m_tbl [1024];
  longint m_cnt, m_idx, m_sub, m_x, m_i1, m_i2, m_u, m_y, m_nx, m_n, m_p;
  bit     m_clk, m_dat, m_syncq, m_rise;
  localparam longint FS = 64'sd1 << 23;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_clk = 0; m_dat = 0; m_idx = 0; m_sub = 0;
      m_x = 0; m_i1 = 0; m_i2 = 0; m_syncq = 0;
    end else begin
      m_rise  = sync_in && !m_syncq;
      m_syncq = sync_in;
      m_n = longint'(cfg_interp) + 1;
      m_p = 64'sd2 << cfg_rate;
      if (!run_en) begin
        m_cnt = 0; m_clk = 0; m_dat = 0; m_idx = 0; m_sub = 0;
        m_x = m_n * m_tbl[0]; m_i1 = 0; m_i2 = 0;
      end else if (m_rise && cfg_sync_en) begin
        m_cnt = 0; m_clk = 0; m_idx = 0; m_sub = 0; m_x = m_n * m_tbl[0];
      end else begin
        m_cnt = (m_cnt == m_p - 1) ? 0 : m_cnt + 1;
        if (m_clk && m_cnt == m_p / 2) begin
          m_u  = (m_x * longint'(cfg_gain)) >>> 24;
          m_y  = (m_i2 >= 0) ? FS : -FS;
          m_i1 = m_i1 + m_u - m_y;
          m_i2 = m_i2 + m_i1 - m_y;
          m_dat = (m_i2 >= 0);
          m_nx = (m_idx == longint'(cfg_last)) ? 0 : m_idx + 1;
          if (m_sub == longint'(cfg_interp)) begin
            m_sub = 0; m_x = m_n * m_tbl[m_nx]; m_idx = m_nx;
          end else begin
            m_sub = m_sub + 1; m_x = m_x + m_tbl[m_nx] - m_tbl[m_idx];
          end
        end
        m_clk = (m_cnt < m_p / 2);
      end
    end
    if (tbl_we) m_tbl[tbl_waddr] = longint'($signed(tbl_wdata));
  end

  // per-cycle comparison away from the active edge
  bit prev_clk = 0, prev_dat = 0, prev_run = 0, dens_on = 0;
  int ones = 0, nbits = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bit_clk_o !== m_clk) begin
        errors++;
        $display("FAIL R2 (%s) bit_clk actual=%0b expected=%0b t=%0t", tag, bit_clk_o, m_clk, $time);
      end
      checks++;
      if (bit_data_o !== m_dat) begin
        errors++;
        $display("FAIL %s bit_data actual=%0b expected=%0b t=%0t", tag, bit_data_o, m_dat, $time);
      end
      if (prev_run && bit_data_o != prev_dat) begin
        checks++;
        if (!(prev_clk && !bit_clk_o)) begin
          errors++;
          $display("FAIL R3 data change without clock fall actual_clk=%0b%0b expected=10", prev_clk, bit_clk_o);
        end
      end
      if (dens_on && prev_clk && !bit_clk_o) begin
        nbits++;
        ones += int'(bit_data_o);
      end
    end
    prev_clk = bit_clk_o; prev_dat = bit_data_o; prev_run = run_en;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_sine(input int pts, input real amp);
    for (int k = 0; k < pts; k++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = 10'(k);
      tbl_wdata = 24'(int'(amp * $sin(2.0 * 3.14159265358979 * k / pts)));
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic stop_run;
    @(negedge clk); run_en = 1'b0;
    tag = "R8";
    cycles(2);
    checks++;
    if (bit_clk_o !== 1'b0 || bit_data_o !== 1'b0) begin
      errors++;
      $display("FAIL R8 idle outputs actual=%0b%0b expected=00", bit_clk_o, bit_data_o);
    end
    cycles(4);
  endtask

  task automatic finish_report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cycles(4);
    rst_n = 1'b1;
    cycles(2);
    // R8: reset state
    checks++;
    if (bit_clk_o !== 1'b0 || bit_data_o !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset outputs actual=%0b%0b expected=00", bit_clk_o, bit_data_o);
    end

    // R1/R4/R6/R7: 64-point sine, interpolation 4, fastest rate
    load_sine(64, 4194304.0);
    cfg_interp = 8'd3; cfg_rate = 3'd0; cfg_gain = 24'd4194304; cfg_last = 10'd63;
    cycles(3);
    tag = "R1/R4/R6/R7";
    run_en = 1'b1;
    cycles(2500);
    stop_run();

    // R2/R5: slower bit clock, no interpolation, wrap after entry 9
    cfg_interp = 8'd0; cfg_rate = 3'd2; cfg_gain = 24'hFFFFFF; cfg_last = 10'd9;
    cycles(3);
    tag = "R2/R5";
    run_en = 1'b1;
    cycles(3000);
    stop_run();

    // R9: resync enabled, interpolation 16
    cfg_interp = 8'd15; cfg_rate = 3'd1; cfg_gain = 24'd1048576; cfg_last = 10'd63;
    cfg_sync_en = 1'b1;
    cycles(3);
    tag = "R9";
    run_en = 1'b1;
    for (int p = 0; p < 4; p++) begin
      cycles(613 + 37 * p);
      sync_in = 1'b1; cycles(3); sync_in = 1'b0;
    end
    cycles(400);
    stop_run();

    // R10: resync disabled, same pulses must leave the stream alone
    cfg_sync_en = 1'b0;
    cycles(3);
    tag = "R10";
    run_en = 1'b1;
    for (int p = 0; p < 4; p++) begin
      cycles(613 + 37 * p);
      sync_in = 1'b1; cycles(3); sync_in = 1'b0;
    end
    cycles(400);
    stop_run();

    // R11: constant input of one eighth of full scale
    @(negedge clk); tbl_we = 1'b1; tbl_waddr = '0; tbl_wdata = 24'd2097152;
    @(negedge clk); tbl_we = 1'b0;
    cfg_interp = 8'd0; cfg_rate = 3'd0; cfg_gain = 24'd8388608; cfg_last = 10'd0;
    cycles(3);
    tag = "R11/R5";
    run_en = 1'b1;
    cycles(64);
    dens_on = 1'b1;
    while (nbits < 512) cycles(1);
    dens_on = 1'b0;
    checks++;
    if (ones < 282 || ones > 294) begin
      errors++;
      $display("FAIL R11 ones in 512 bits actual=%0d expected=288", ones);
    end
    stop_run();

    done = 1'b1;
    finish_report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finish_report();
    end
  end
endmodule